// File: doc/BRIEF.md
# Host-Controlled Pseudo-Random Word Generator

This block holds a 16-bit pseudo-random word. Link-layer software uses it to pick a random terminal address. The word advances on every clock while the generator runs. A host reaches it through four byte strobes: a read and a write for the low byte, and a read and a write for the high byte. The host strobes start and stop the generator, and the low and high bytes have different effects. A read of either byte freezes the word. A write of the high byte loads that byte and freezes the word. A write of the low byte loads that byte and sets the generator running again.

Both bytes of the word appear on registered outputs, together with a flag that shows whether the generator is running. A read freezes the word at the clock edge of the access. The bytes the host sees after that edge are therefore the value it sampled, and a following read of the other byte returns the other half of the same word. Reset is synchronous and active high. It clears the word and leaves the generator running, so the word starts stepping as soon as reset is released.

Top module: `addr_rng_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the word becomes 0x0000 and `running` becomes 1.
- R2: On the first running step after reset, the zero word is replaced by 0x0001.
- R3: While `running` is 1 and no strobe is asserted, each clock edge changes the word W to {W[14:0], W[15]^W[13]^W[12]^W[10]} (taps 16,14,13,11; `lo_byte` is W[7:0], `hi_byte` is W[15:8]).
- R4: A cycle with `rd_lo` high clears `running` at that edge, and the word does not advance at that edge.
- R5: A cycle with `rd_hi` high clears `running` at that edge, and the word does not advance at that edge.
- R6: A cycle with `wr_hi` high loads `wdata` into `hi_byte`, leaves `lo_byte` unchanged and clears `running`. The generator stays stopped until a low-byte write arrives.
- R7: A cycle with `wr_lo` high and no other strobe loads `wdata` into `lo_byte`, leaves `hi_byte` unchanged and sets `running`. Stepping resumes at the following edge.
- R8: While `running` is 0 and no write strobe is asserted, the word holds its value.
- R9: When `wr_lo` arrives in the same cycle as `rd_lo`, `rd_hi` or `wr_hi`, the stop wins and `running` becomes 0. Every byte whose write strobe is high is still loaded.
- R10: A running word that is 0x0000 (for example after both bytes are written with zero) steps to 0x0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_lo | input | 1 | Host read strobe for the low byte |
| rd_hi | input | 1 | Host read strobe for the high byte |
| wr_lo | input | 1 | Host write strobe for the low byte |
| wr_hi | input | 1 | Host write strobe for the high byte |
| wdata | input | 8 | Write data byte |
| lo_byte | output | 8 | Low byte of the word (registered) |
| hi_byte | output | 8 | High byte of the word (registered) |
| running | output | 1 | 1 while the generator steps |

## Verification
The bench aims at the asymmetry between the two write strobes. If the effects were swapped, a high-byte write would leave `running` set, or a low-byte write would leave the word frozen. It also targets the freeze edge of a read: a design that advanced once more after the read would show the host a word that differs from the one it sampled. Collisions where `wr_lo` meets a read or `wr_hi` are driven to expose a start that wrongly beats a stop. A zero word loaded while running must step to 0x0001; a design that missed this would lock up at zero forever.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned RNG_BYTE_W = 8;
  localparam int unsigned RNG_NBYTES = 2;
  localparam int unsigned RNG_WIDTH  = RNG_BYTE_W * RNG_NBYTES;
  // feedback positions 16,14,13,11 -> bits 15,13,12,10
  localparam logic [RNG_WIDTH-1:0] RNG_TAPS = 16'hB400;

  typedef struct packed {
    logic rd_lo;
    logic rd_hi;
    logic wr_lo;
    logic wr_hi;
  } host_acc_t;
endpackage

// File: rtl/rng_access_decode.sv
module rng_access_decode
  import rng_pkg::*;
#(
  parameter int unsigned NBYTES = RNG_NBYTES
) (
  input  host_acc_t         acc,
  input  logic              run_q,
  output logic              freeze,
  output logic              start,
  output logic              step_en,
  output logic [NBYTES-1:0] load_en
);
  logic any_acc;

  always_comb begin
    freeze   = acc.rd_lo | acc.rd_hi | acc.wr_hi;
    start    = acc.wr_lo & ~freeze;
    any_acc  = freeze | acc.wr_lo;
    step_en  = run_q & ~any_acc;
    load_en    = '0;
    load_en[0] = acc.wr_lo;
    load_en[NBYTES-1] = acc.wr_hi;
  end
endmodule

// File: rtl/rng_run_ctrl.sv
module rng_run_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  input  logic start,
  output logic run_q
);
  always_ff @(posedge clk) begin
    if (rst)         run_q <= 1'b1;
    else if (freeze) run_q <= 1'b0;
    else if (start)  run_q <= 1'b1;
  end
endmodule

// File: rtl/rng_lfsr_core.sv
module rng_lfsr_core
  import rng_pkg::*;
#(
  parameter int unsigned BYTE_W = RNG_BYTE_W,
  parameter int unsigned NBYTES = RNG_NBYTES,
  parameter logic [BYTE_W*NBYTES-1:0] TAPS = RNG_TAPS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step_en,
  input  logic [NBYTES-1:0]          load_en,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [BYTE_W*NBYTES-1:0]   word_q
);
  localparam int unsigned WIDTH = BYTE_W * NBYTES;

  logic [WIDTH-1:0]  nxt;
  logic              fb;
  logic [BYTE_W-1:0] lane_q [NBYTES];

  always_comb begin
    fb = ^(word_q & TAPS);
    if (word_q == '0) nxt = {{(WIDTH-1){1'b0}}, 1'b1};
    else              nxt = {word_q[WIDTH-2:0], fb};
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)             lane_q[b] <= '0;
      else if (load_en[b]) lane_q[b] <= wdata;
      else if (step_en)    lane_q[b] <= nxt[b*BYTE_W +: BYTE_W];
    end
    assign word_q[b*BYTE_W +: BYTE_W] = lane_q[b];
  end
endmodule

// File: rtl/addr_rng_gen.sv
module addr_rng_gen
  import rng_pkg::*;
#(
  parameter int unsigned BYTE_W = RNG_BYTE_W,
  parameter logic [2*BYTE_W-1:0] TAPS = RNG_TAPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte,
  output logic              running
);
  localparam int unsigned NBYTES = 2;
  localparam int unsigned WIDTH  = BYTE_W * NBYTES;

  host_acc_t         acc;
  logic              freeze, start, step_en, run_q;
  logic [NBYTES-1:0] load_en;
  logic [WIDTH-1:0]  word_q;

  assign acc = '{rd_lo: rd_lo, rd_hi: rd_hi, wr_lo: wr_lo, wr_hi: wr_hi};

  rng_access_decode #(.NBYTES(NBYTES)) u_dec (
    .acc(acc), .run_q(run_q), .freeze(freeze), .start(start),
    .step_en(step_en), .load_en(load_en)
  );

  rng_run_ctrl u_run (
    .clk(clk), .rst(rst), .freeze(freeze), .start(start), .run_q(run_q)
  );

  rng_lfsr_core #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .TAPS(TAPS)) u_core (
    .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en),
    .wdata(wdata), .word_q(word_q)
  );

  assign lo_byte = word_q[BYTE_W-1:0];
  assign hi_byte = word_q[WIDTH-1:BYTE_W];
  assign running = run_q;
endmodule

// File: rtl/rng_checker.sv
module rng_checker #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] lo_byte,
  input logic [BYTE_W-1:0] hi_byte,
  input logic              running
);
  logic [2*BYTE_W-1:0] w;
  logic idle;
  assign w    = {hi_byte, lo_byte};
  assign idle = !(rd_lo || rd_hi || wr_lo || wr_hi);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (w == '0 && running));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (running && idle && w != '0) |=>
      (w == {$past(w[2*BYTE_W-2:0]),
             $past(w[15] ^ w[13] ^ w[12] ^ w[10])}));

  assert_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (running && idle && w == '0) |=> (w == 1));

  assert_rdlo_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !wr_lo && !wr_hi) |=> (!running && $stable(w)));

  assert_rdhi_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_hi && !wr_lo && !wr_hi) |=> (!running && $stable(w)));

  assert_wrhi_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> (!running && hi_byte == $past(wdata) && $stable(lo_byte)));

  assert_wrlo_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi && !rd_lo && !rd_hi) |=>
      (running && lo_byte == $past(wdata) && $stable(hi_byte)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!running && !wr_lo && !wr_hi) |=> $stable(w));

  assert_stopwins_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && (rd_lo || rd_hi || wr_hi)) |=> (!running && lo_byte == $past(wdata)));
endmodule

bind addr_rng_gen rng_checker #(.BYTE_W(BYTE_W)) u_rng_chk (
  .clk(clk), .rst(rst), .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_lo(wr_lo),
  .wr_hi(wr_hi), .wdata(wdata), .lo_byte(lo_byte), .hi_byte(hi_byte),
  .running(running)
);

// File: tb/addr_rng_gen_bench.sv
module addr_rng_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_lo = 1'b0, rd_hi = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] lo_byte, hi_byte;
  logic running;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int        due;
    logic [15:0] word;
    logic      run;
    string     tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] m_word = 16'h0000;
  logic        m_run  = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  addr_rng_gen u_addr_rng_gen (
    .clk(clk), .rst(rst), .rd_lo(rd_lo), .rd_hi(rd_hi), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wdata(wdata), .lo_byte(lo_byte), .hi_byte(hi_byte),
    .running(running)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] model_step(logic [15:0] v);
    if (v == 16'h0000) return 16'h0001;
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // driver: one cycle of stimulus plus the predicted state after the edge
  task automatic drive(input logic r, input logic rl, input logic rh,
                       input logic wl, input logic wh, input logic [7:0] d,
                       input string tag);
    exp_t e;
    logic stop;
    @(negedge clk);
    rst = r; rd_lo = rl; rd_hi = rh; wr_lo = wl; wr_hi = wh; wdata = d;
    if (r) begin
      m_word = 16'h0000;
      m_run  = 1'b1;
    end else begin
      stop = rl | rh | wh;
      if (wl) m_word[7:0]  = d;
      if (wh) m_word[15:8] = d;
      if (m_run && !(rl | rh | wl | wh)) m_word = model_step(m_word);
      if (stop)    m_run = 1'b0;
      else if (wl) m_run = 1'b1;
    end
    e.due = cyc + 1; e.word = m_word; e.run = m_run; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 8'h00, tag);
  endtask

  // monitor: compares results away from the active edge
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if ({hi_byte, lo_byte} !== e.word || running !== e.run) begin
        errors++;
        $display("FAIL %s: got word=%h run=%b expected word=%h run=%b",
                 e.tag, {hi_byte, lo_byte}, running, e.word, e.run);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, 0, 8'h00, "R1 reset");
    drive(0, 0, 0, 0, 0, 8'h00, "R2 first step");
    idle(24, "R3 free run");
    drive(0, 1, 0, 0, 0, 8'h00, "R4 rd_lo freeze");
    idle(4, "R8 hold while stopped");
    drive(0, 0, 1, 0, 0, 8'h00, "R5 rd_hi while stopped");
    drive(0, 0, 0, 1, 0, 8'h5A, "R7 wr_lo restart");
    idle(6, "R3 resumed run");
    drive(0, 0, 1, 0, 0, 8'h00, "R5 rd_hi freeze");
    idle(3, "R8 hold after rd_hi");
    drive(0, 0, 0, 1, 0, 8'hA7, "R7 wr_lo restart");
    idle(3, "R3 run");
    drive(0, 0, 0, 0, 1, 8'hC3, "R6 wr_hi load");
    idle(4, "R6 stays stopped");
    drive(0, 0, 0, 0, 1, 8'h00, "R6 wr_hi zero");
    drive(0, 0, 0, 1, 0, 8'h00, "R7 wr_lo zero");
    idle(3, "R10 zero escapes");
    drive(0, 0, 1, 1, 0, 8'h3C, "R9 wr_lo with rd_hi");
    idle(2, "R9 stays stopped");
    drive(0, 1, 0, 1, 0, 8'h44, "R9 wr_lo with rd_lo");
    idle(2, "R9 stays stopped");
    drive(0, 0, 0, 1, 1, 8'h99, "R9 wr_lo with wr_hi");
    idle(2, "R9 stays stopped");
    drive(0, 0, 0, 1, 0, 8'h01, "R7 restart");
    idle(120, "R3 long run");
    drive(1, 0, 0, 0, 0, 8'h00, "R1 reset mid-run");
    drive(0, 0, 0, 0, 0, 8'h00, "R2 first step again");
    idle(5, "R3 run after reset");
    idle(2, "drain");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule